// File: doc/BRIEF.md
# Dual-Channel DAC Code Register Front End

This block sits between a microprocessor bus and a pair of 12-bit converters. A host writes each channel's code as three 4-bit pieces over a narrow data bus. A 3-bit address picks the channel and the piece. Every piece lands in a per-channel staging (input) register. The value reaches the converter-facing (DAC) register only when the host asks for a transfer. The host can transfer one channel by address, or both channels at once with a separate update strobe. With the update strobe, the two outputs change on the same clock edge.

All bus strobes are active low, except clear, which is active high. The block runs from a system clock. It passes the strobes, address and data through a flip-flop synchronizer. A bus write acts exactly once, when the synchronized write strobe returns high. The write uses the address, data, select and update levels that were held while write was low. Clear zeroes every register for as long as it stays high.

Top module: `dual_dac_nibble_front`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, both `dac_a` and `dac_b` read zero.
- R2: A write with `cs_n` low stores `bus_data` in one nibble of one channel's input register. `bus_addr[2]` picks the channel (0 for A, 1 for B). `bus_addr[1:0]` picks the position: 00 for bits 3:0, 01 for bits 7:4, 10 for bits 11:8.
- R3: A write with `cs_n` low and `bus_addr[1:0]` = 11 copies the addressed channel's input register into its DAC register. The other channel's output does not change.
- R4: A write with `upd_n` low and `cs_n` high loads both DAC registers from their input registers on the same clock edge. Address and data have no effect.
- R5: While `clr` is high, every input and DAC register is forced to zero on each clock. A later update therefore yields zero on both outputs.
- R6: A write with both `cs_n` and `upd_n` high changes nothing. Levels on the bus while `wr_n` stays high also change nothing.
- R7: A write takes effect once, after `wr_n` rises, and within four clock cycles of the rise. No output moves while `wr_n` is held low.
- R8: Loading nibbles never changes `dac_a` or `dac_b` unless a transfer or an update happens in the same write.
- R9: A write with both `cs_n` and `upd_n` low first applies the addressed nibble load or transfer. It then loads both DAC registers from the new input values.
- R10: A write that completes while the synchronized clear is high is discarded. After clear drops, an update still yields zero on both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 4 | Nibble data from the host |
| bus_addr | input | 3 | Channel (bit 2) and nibble or transfer code (bits 1:0) |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| upd_n | input | 1 | Active-low simultaneous-update strobe |
| clr | input | 1 | Active-high clear of all registers |
| dac_a | output | 12 | Channel A DAC register code |
| dac_b | output | 12 | Channel B DAC register code |

## Verification
The bench targets four corner cases. The first is a write that asserts select and update together. A design that updated before loading the nibble would present the previous code instead of the new one. The second is a write that ends inside a clear. A design that let it through would leave a non-zero staging value, which the next update then exposes. The third is a write held low for a long time. A level-triggered design would move the output before the strobe rises, or apply the write several times. The fourth is a write with both select and update high, which must leave the next update's result unchanged. Random bus cycles against a register-level model then cover the mixing of channels and nibble positions.

// File: rtl/ddac_pkg.sv
package ddac_pkg;

   localparam int unsigned ADDR_W   = 3;
   localparam int unsigned CHAN_CNT = 2;

   // Low two address bits: nibble slot or transfer request.
   typedef enum logic [1:0] {
      SLOT_LOW  = 2'd0,
      SLOT_MID  = 2'd1,
      SLOT_HIGH = 2'd2,
      SLOT_XFER = 2'd3
   } slot_e;

endpackage

// File: rtl/ddac_strobe_sync.sv
module ddac_strobe_sync #(
   parameter int unsigned       WIDTH  = 1,
   parameter int unsigned       STAGES = 2,
   parameter logic [WIDTH-1:0]  IDLE   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ddac_strobe_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ddac_strobe_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= {STAGES{IDLE}};
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], d};
      end
   end

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/ddac_bus_decode.sv
module ddac_bus_decode #(
   parameter int unsigned NIB_W    = 4,
   parameter int unsigned NIB_CNT  = 3,
   parameter int unsigned CHAN_CNT = ddac_pkg::CHAN_CNT,
   parameter int unsigned ADDR_W   = ddac_pkg::ADDR_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s_wr_n,
   input  logic                s_cs_n,
   input  logic                s_upd_n,
   input  logic                s_clr,
   input  logic [ADDR_W-1:0]   s_addr,
   input  logic [NIB_W-1:0]    s_data,
   output logic                ev_fire,
   output logic                ev_cs_n,
   output logic                ev_upd_n,
   output logic [1:0]          nib_slot,
   output logic [NIB_W-1:0]    nib_data,
   output logic [CHAN_CNT-1:0] nib_we,
   output logic [CHAN_CNT-1:0] xfer,
   output logic                upd_all
);

   generate
      if (ADDR_W != 3) begin : g_bad_addr
         $error("ddac_bus_decode: address must be 3 bits (channel + slot)");
      end
      if (CHAN_CNT != 2) begin : g_bad_chan
         $error("ddac_bus_decode: exactly two channels are decoded");
      end
   endgenerate

   logic              wr_prev_q;
   logic              cap_cs_n_q;
   logic              cap_upd_n_q;
   logic [ADDR_W-1:0] cap_addr_q;
   logic [NIB_W-1:0]  cap_data_q;

   // Hold the bus while the synchronized write is low; act on its rise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev_q   <= 1'b1;
         cap_cs_n_q  <= 1'b1;
         cap_upd_n_q <= 1'b1;
         cap_addr_q  <= '0;
         cap_data_q  <= '0;
      end else begin
         wr_prev_q <= s_wr_n;
         if (!s_wr_n) begin
            cap_cs_n_q  <= s_cs_n;
            cap_upd_n_q <= s_upd_n;
            cap_addr_q  <= s_addr;
            cap_data_q  <= s_data;
         end
      end
   end

   logic slot_is_xfer;
   logic slot_in_range;

   assign ev_fire       = s_wr_n & ~wr_prev_q & ~s_clr;
   assign ev_cs_n       = cap_cs_n_q;
   assign ev_upd_n      = cap_upd_n_q;
   assign nib_slot      = cap_addr_q[1:0];
   assign nib_data      = cap_data_q;
   assign slot_is_xfer  = (cap_addr_q[1:0] == ddac_pkg::SLOT_XFER);
   assign slot_in_range = (cap_addr_q[1:0] < 2'(NIB_CNT));
   assign upd_all       = ev_fire & ~cap_upd_n_q;

   generate
      for (genvar ch = 0; ch < CHAN_CNT; ch++) begin : g_chan_dec
         logic chan_hit;
         assign chan_hit   = ev_fire & ~cap_cs_n_q & (cap_addr_q[ADDR_W-1] == 1'(ch));
         assign nib_we[ch] = chan_hit & ~slot_is_xfer & slot_in_range;
         assign xfer[ch]   = chan_hit & slot_is_xfer;
      end
   endgenerate

endmodule

// File: rtl/ddac_channel_regs.sv
module ddac_channel_regs #(
   parameter  int unsigned NIB_W   = 4,
   parameter  int unsigned NIB_CNT = 3,
   localparam int unsigned CODE_W  = NIB_W * NIB_CNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              nib_we,
   input  logic [1:0]        nib_slot,
   input  logic [NIB_W-1:0]  nib_data,
   input  logic              xfer,
   input  logic              upd,
   output logic [CODE_W-1:0] in_word,
   output logic [CODE_W-1:0] dac_word
);

   generate
      if (NIB_CNT < 1 || NIB_CNT > 3) begin : g_bad_cnt
         $error("ddac_channel_regs: NIB_CNT must be 1..3 (slot 3 is the transfer code)");
      end
   endgenerate

   logic [NIB_CNT-1:0][NIB_W-1:0] in_q;
   logic [NIB_CNT-1:0][NIB_W-1:0] in_nx;
   logic [CODE_W-1:0]             dac_q;

   generate
      for (genvar n = 0; n < NIB_CNT; n++) begin : g_nib
         assign in_nx[n] = (nib_we && nib_slot == 2'(n)) ? nib_data : in_q[n];
      end
   endgenerate

   // A transfer or update sees the nibble written by the same event.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         dac_q <= '0;
      end else if (clr) begin
         in_q  <= '0;
         dac_q <= '0;
      end else begin
         in_q <= in_nx;
         if (xfer || upd) begin
            dac_q <= in_nx;
         end
      end
   end

   assign in_word  = in_q;
   assign dac_word = dac_q;

endmodule

// File: rtl/dual_dac_nibble_front.sv
module dual_dac_nibble_front #(
   parameter  int unsigned NIB_W       = 4,
   parameter  int unsigned NIB_CNT     = 3,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned CODE_W      = NIB_W * NIB_CNT
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NIB_W-1:0]            bus_data,
   input  logic [ddac_pkg::ADDR_W-1:0] bus_addr,
   input  logic                        cs_n,
   input  logic                        wr_n,
   input  logic                        upd_n,
   input  logic                        clr,
   output logic [CODE_W-1:0]           dac_a,
   output logic [CODE_W-1:0]           dac_b
);

   localparam int unsigned ADDR_W   = ddac_pkg::ADDR_W;
   localparam int unsigned CHAN_CNT = ddac_pkg::CHAN_CNT;
   localparam int unsigned SYNC_W   = 4 + ADDR_W + NIB_W;
   localparam logic [SYNC_W-1:0] SYNC_IDLE = {3'b111, 1'b0, {(ADDR_W + NIB_W){1'b0}}};

   logic [SYNC_W-1:0] raw_bus;
   logic [SYNC_W-1:0] sync_bus;

   assign raw_bus = {wr_n, cs_n, upd_n, clr, bus_addr, bus_data};

   ddac_strobe_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES),
      .IDLE   (SYNC_IDLE)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_bus),
      .q     (sync_bus)
   );

   logic              s_wr_n;
   logic              s_cs_n;
   logic              s_upd_n;
   logic              s_clr;
   logic [ADDR_W-1:0] s_addr;
   logic [NIB_W-1:0]  s_data;

   assign {s_wr_n, s_cs_n, s_upd_n, s_clr, s_addr, s_data} = sync_bus;

   logic                ev_fire;
   logic                ev_cs_n;
   logic                ev_upd_n;
   logic [1:0]          nib_slot;
   logic [NIB_W-1:0]    nib_data;
   logic [CHAN_CNT-1:0] nib_we;
   logic [CHAN_CNT-1:0] xfer;
   logic                upd_all;

   ddac_bus_decode #(
      .NIB_W    (NIB_W),
      .NIB_CNT  (NIB_CNT),
      .CHAN_CNT (CHAN_CNT),
      .ADDR_W   (ADDR_W)
   ) dec_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_wr_n   (s_wr_n),
      .s_cs_n   (s_cs_n),
      .s_upd_n  (s_upd_n),
      .s_clr    (s_clr),
      .s_addr   (s_addr),
      .s_data   (s_data),
      .ev_fire  (ev_fire),
      .ev_cs_n  (ev_cs_n),
      .ev_upd_n (ev_upd_n),
      .nib_slot (nib_slot),
      .nib_data (nib_data),
      .nib_we   (nib_we),
      .xfer     (xfer),
      .upd_all  (upd_all)
   );

   logic [CHAN_CNT-1:0][CODE_W-1:0] in_v;
   logic [CHAN_CNT-1:0][CODE_W-1:0] dac_v;

   generate
      for (genvar ch = 0; ch < CHAN_CNT; ch++) begin : g_chan
         ddac_channel_regs #(
            .NIB_W   (NIB_W),
            .NIB_CNT (NIB_CNT)
         ) regs_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (s_clr),
            .nib_we   (nib_we[ch]),
            .nib_slot (nib_slot),
            .nib_data (nib_data),
            .xfer     (xfer[ch]),
            .upd      (upd_all),
            .in_word  (in_v[ch]),
            .dac_word (dac_v[ch])
         );
      end
   endgenerate

   assign dac_a = dac_v[0];
   assign dac_b = dac_v[1];

endmodule

// File: rtl/ddac_checker.sv
module ddac_checker #(
   parameter int unsigned CODE_W = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   clr,
   input logic                   wr_n,
   input logic [CODE_W-1:0]      dac_a,
   input logic [CODE_W-1:0]      dac_b,
   input logic [1:0][CODE_W-1:0] in_v,
   input logic                   s_clr,
   input logic                   ev_fire,
   input logic                   ev_cs_n,
   input logic                   ev_upd_n,
   input logic [1:0]             nib_we,
   input logic [1:0]             xfer,
   input logic                   upd_all
);

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (dac_a == '0 && dac_b == '0)); // R1

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nib_we, xfer})); // R2

   AST_XFER_A: assert property (@(posedge clk) disable iff (!rst_n)
      xfer[0] |=> (dac_a == in_v[0])); // R3

   AST_XFER_B: assert property (@(posedge clk) disable iff (!rst_n)
      xfer[1] |=> (dac_b == in_v[1])); // R3

   AST_UPD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      upd_all |=> (dac_a == in_v[0] && dac_b == in_v[1])); // R4

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      s_clr |=> (in_v == '0 && dac_a == '0 && dac_b == '0)); // R5

   AST_CLR_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && $past(clr) && $past(clr, 2)) |=> (dac_a == '0 && dac_b == '0)); // R5

   AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_fire && ev_cs_n && ev_upd_n) |=> ($stable(in_v) && $stable(dac_a) && $stable(dac_b))); // R6

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n && $past(wr_n) && $past(wr_n, 2) && $past(wr_n, 3) &&
       !clr && !$past(clr) && !$past(clr, 2)) |=> ($stable(dac_a) && $stable(dac_b))); // R7

   AST_NIBBLE_NO_DAC: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_we != 2'b00 && xfer == 2'b00 && !upd_all && !s_clr) |=> ($stable(dac_a) && $stable(dac_b))); // R8

endmodule

bind dual_dac_nibble_front ddac_checker #(
   .CODE_W (CODE_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .wr_n     (wr_n),
   .dac_a    (dac_a),
   .dac_b    (dac_b),
   .in_v     (in_v),
   .s_clr    (s_clr),
   .ev_fire  (ev_fire),
   .ev_cs_n  (ev_cs_n),
   .ev_upd_n (ev_upd_n),
   .nib_we   (nib_we),
   .xfer     (xfer),
   .upd_all  (upd_all)
);

// File: tb/dual_dac_nibble_front_tb.sv
module dual_dac_nibble_front_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_data = '0;
   logic [2:0]  bus_addr = '0;
   logic        cs_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        upd_n = 1'b1;
   logic        clr = 1'b0;
   logic [11:0] dac_a;
   logic [11:0] dac_b;

   int total = 0;
   int bad   = 0;

   // Reference: three nibbles per channel plus a DAC word per channel.
   logic [3:0]  m_in [2][3];
   logic [11:0] m_dac [2];

   always #2 clk = ~clk;

   dual_dac_nibble_front dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_data (bus_data),
      .bus_addr (bus_addr),
      .cs_n     (cs_n),
      .wr_n     (wr_n),
      .upd_n    (upd_n),
      .clr      (clr),
      .dac_a    (dac_a),
      .dac_b    (dac_b)
   );

   function automatic logic [11:0] staged(input int ch);
      return {m_in[ch][2], m_in[ch][1], m_in[ch][0]};
   endfunction

   task automatic model_clear();
      for (int c = 0; c < 2; c++) begin
         for (int n = 0; n < 3; n++) m_in[c][n] = '0;
         m_dac[c] = '0;
      end
   endtask

   task automatic model_write(input logic [2:0] a, input logic [3:0] d,
                              input logic c, input logic u);
      int ch;
      ch = int'(a[2]);
      if (!c) begin
         if (a[1:0] != 2'b11) m_in[ch][a[1:0]] = d;
         else                 m_dac[ch] = staged(ch);
      end
      if (!u) begin
         m_dac[0] = staged(0);
         m_dac[1] = staged(1);
      end
   endtask

   task automatic check12(input logic [11:0] act, input logic [11:0] exp,
                          input string rq, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%03h expected=%03h", rq, what, act, exp);
      end
   endtask

   task automatic check_outs(input string rq);
      check12(dac_a, m_dac[0], rq, "dac_a");
      check12(dac_b, m_dac[1], rq, "dac_b");
   endtask

   task automatic bus_cycle(input logic [2:0] a, input logic [3:0] d,
                            input logic c, input logic u, input int low_cyc);
      @(negedge clk);
      bus_addr = a; bus_data = d; cs_n = c; upd_n = u; wr_n = 1'b0;
      repeat (low_cyc) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      cs_n = 1'b1; upd_n = 1'b1;
   endtask

   task automatic do_write(input logic [2:0] a, input logic [3:0] d,
                           input logic c, input logic u, input string rq);
      bus_cycle(a, d, c, u, 3);
      model_write(a, d, c, u);
      check_outs(rq);
   endtask

   task automatic do_clear(input int cyc);
      @(negedge clk);
      clr = 1'b1;
      repeat (cyc) @(negedge clk);
      clr = 1'b0;
      repeat (4) @(negedge clk);
      model_clear();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      string rq;
      void'($urandom(32'd20240611));
      model_clear();

      // R1: reset state
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R1");

      // R2 / R8: nibble loads into A stay invisible
      do_write(3'b000, 4'h3, 1'b0, 1'b1, "R8");
      do_write(3'b001, 4'hA, 1'b0, 1'b1, "R8");
      do_write(3'b010, 4'h5, 1'b0, 1'b1, "R2");
      // R3: transfer channel A only
      do_write(3'b011, 4'h0, 1'b0, 1'b1, "R3");
      check12(dac_a, 12'h5A3, "R3", "dac_a literal");

      // R8 on channel B, then R4 simultaneous update
      do_write(3'b100, 4'hF, 1'b0, 1'b1, "R8");
      do_write(3'b101, 4'h1, 1'b0, 1'b1, "R8");
      do_write(3'b110, 4'hC, 1'b0, 1'b1, "R8");
      do_write(3'b000, 4'h7, 1'b1, 1'b0, "R4");
      check12(dac_b, 12'hC1F, "R4", "dac_b literal");
      check12(dac_a, 12'h5A3, "R4", "dac_a address ignored");

      // R6: deselected write, then bus activity with write held high
      do_write(3'b000, 4'h9, 1'b1, 1'b1, "R6");
      @(negedge clk);
      bus_addr = 3'b000; bus_data = 4'h9; cs_n = 1'b0; upd_n = 1'b0;
      repeat (10) @(negedge clk);
      cs_n = 1'b1; upd_n = 1'b1;
      check_outs("R6");
      do_write(3'b000, 4'h0, 1'b1, 1'b0, "R6");
      check12(dac_a, 12'h5A3, "R6", "dac_a after ignored writes");

      // R9: nibble load plus update in one write
      do_write(3'b100, 4'h6, 1'b0, 1'b0, "R9");
      check12(dac_b, 12'hC16, "R9", "dac_b literal");

      // R3: transfer B leaves A alone although A's input changed
      do_write(3'b010, 4'h0, 1'b0, 1'b1, "R8");
      do_write(3'b111, 4'h0, 1'b0, 1'b1, "R3");
      check12(dac_a, 12'h5A3, "R3", "dac_a untouched");

      // R9: transfer plus update in one write
      do_write(3'b011, 4'h0, 1'b0, 1'b0, "R9");
      check12(dac_a, 12'h0A3, "R9", "dac_a literal");

      // R5: clear zeroes outputs and staging
      do_clear(4);
      check_outs("R5");
      do_write(3'b000, 4'h0, 1'b1, 1'b0, "R5");

      // R10: write completing during clear is dropped
      do_write(3'b000, 4'h8, 1'b0, 1'b1, "R2");
      do_write(3'b011, 4'h0, 1'b0, 1'b1, "R3");
      check12(dac_a, 12'h008, "R3", "dac_a before clear");
      @(negedge clk);
      clr = 1'b1;
      repeat (3) @(negedge clk);
      bus_cycle(3'b001, 4'hF, 1'b0, 1'b0, 3);
      clr = 1'b0;
      repeat (4) @(negedge clk);
      model_clear();
      check_outs("R10");
      do_write(3'b000, 4'h0, 1'b1, 1'b0, "R10");

      // R7: long write strobe, no movement until it rises, one effect
      @(negedge clk);
      bus_addr = 3'b100; bus_data = 4'h2; cs_n = 1'b0; upd_n = 1'b0; wr_n = 1'b0;
      repeat (20) @(negedge clk);
      check_outs("R7");
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      cs_n = 1'b1; upd_n = 1'b1;
      model_write(3'b100, 4'h2, 1'b0, 1'b0);
      check_outs("R7");
      check12(dac_b, 12'h002, "R7", "dac_b literal");

      // Random bus cycles mixed with occasional clears
      for (int i = 0; i < 400; i++) begin
         logic [2:0] a;
         logic [3:0] d;
         logic       c;
         logic       u;
         if ($urandom_range(39) == 0) begin
            do_clear(3);
            check_outs("R5");
         end else begin
            a = 3'($urandom);
            d = 4'($urandom);
            c = ($urandom_range(3) == 0);
            u = ($urandom_range(3) != 0);
            if (c && u)              rq = "R6";
            else if (!c && !u)       rq = "R9";
            else if (!u)             rq = "R4";
            else if (a[1:0] == 2'b11) rq = "R3";
            else                     rq = "R2";
            do_write(a, d, c, u, rq);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule